// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers eight event sources from a serial bus controller into one sticky status register. Software enables individual events through a mask register, and the unit drives a single interrupt line whenever any pending status bit is also enabled. Software acknowledges events by writing ones to the status register. A write of 0xFF acknowledges everything at once.

Six of the sources are one-cycle event pulses: packet done, all packets done, transmit overflow, receive underflow, missing acknowledge and lost arbitration. The two data-request sources are live FIFO levels. They set their bit on every cycle they are high, so an acknowledge only holds once the FIFO condition has gone away.

An optional wrapper stage, chosen by a parameter, adds a second done flag. A packet-done event sets this flag when a done-enable bit is on. The flag reaches the interrupt line only when a global enable bit is on, and software acknowledges it separately.

Top module: `irq_stat_unit`

## Requirements
- R1: After a synchronous reset, every stored bit is zero and `irq_o` is low: status, mask, wrapper enables and the wrapper done flag.
- R2: Input `src_i[i]` sets status bit i. The bit map is: 7 packet done, 6 all packets done, 5 transmit overflow, 4 receive underflow, 3 missing acknowledge, 2 arbitration lost, 1 transmit data request, 0 receive data request.
- R3: A write to the status register (address 0) clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. Write data 0xFF clears all eight bits.
- R4: When a source is active and a clear of the same bit happen in the same cycle, the bit stays set.
- R5: A data-request level (bits 0 and 1) held high keeps its status bit set through clears. Once the level is low, a clear removes the bit.
- R6: The mask register (address 1, bits 7:0) reads back the last value written.
- R7: `irq_o` is registered. One cycle after the status AND mask is non-zero, it is high; it is low one cycle after that AND is zero, unless the wrapper path is active.
- R8: Reads have one cycle of latency. `rd_en_i` with `addr_i` returns the value in `rdata_o` at the next edge. The address map is: 0 status, 1 mask, 2 done-enable control at bit 30, 3 global-enable control at bit 10, 4 wrapper status with the done flag at bit 30. All other bits and all other addresses read as zero.
- R9: With the wrapper on, a packet-done event (source bit 7) sets the done flag only while done-enable is 1. Writing 1 to bit 30 of address 4 clears the flag, and a new event in the same cycle wins over the clear.
- R10: The done flag drives `irq_o` only while global-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 8 | Event pulses (bits 7..2) and data-request levels (bits 1..0) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The assertions check several behaviours on every cycle:
- an active source always shows up in status on the next cycle;
- a clear without a competing source empties the written bits;
- status holds when it is neither written nor set;
- the mask loads its written value;
- the interrupt follows status AND mask one cycle later;
- the wrapper flag is gated by its enable.

Only the bench scenarios show the rest:
- that the bit positions match the map;
- how read latency and the address map behave;
- that a held data-request level defeats repeated clears until it drops;
- how the wrapper's global enable interacts with an otherwise masked-off status.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NUM_SRC  = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;

  localparam int PKT_DONE_BIT = 7;
  localparam int WDONE_BIT    = 30;
  localparam int GEN_BIT      = 10;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT  = 3'd0,
    A_MASK  = 3'd1,
    A_WCTLA = 3'd2,
    A_WCTLB = 3'd3,
    A_WSTAT = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (set_i[i])
        stat_q[i] <= 1'b1;
      else if (clr_i[i])
        stat_q[i] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  assert_src_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ((|clr_i) && ((clr_i & set_i) == '0)) |=> ((stat_q & $past(clr_i)) == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ((clr_i == '0) && (set_i == '0)) |=> $stable(stat_q));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (we_i)
      mask_q <= d_i;
  end

  assign mask_o = mask_q;

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mask_q == $past(d_i)));
endmodule

// File: rtl/irq_done_wrap.sv
module irq_done_wrap (
  input  logic clk,
  input  logic rst,
  input  logic we_ena_i,
  input  logic we_gen_i,
  input  logic we_clr_i,
  input  logic ena_d_i,
  input  logic gen_d_i,
  input  logic clr_d_i,
  input  logic pkt_evt_i,
  output logic ena_o,
  output logic gen_o,
  output logic done_o,
  output logic irq_o
);
  logic ena_q, gen_q, done_q;
  logic done_set;

  assign done_set = pkt_evt_i & ena_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q  <= 1'b0;
      gen_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (we_ena_i) ena_q <= ena_d_i;
      if (we_gen_i) gen_q <= gen_d_i;
      if (done_set)
        done_q <= 1'b1;
      else if (we_clr_i && clr_d_i)
        done_q <= 1'b0;
    end
  end

  assign ena_o  = ena_q;
  assign gen_o  = gen_q;
  assign done_o = done_q;
  assign irq_o  = done_q & gen_q;

  assert_done_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
    (!done_q && !(pkt_evt_i && ena_q)) |=> !done_q);

  assert_done_event_R9: assert property (@(posedge clk) disable iff (rst)
    (pkt_evt_i && ena_q) |=> done_q);
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int  N_SRC   = NUM_SRC,
  parameter int  DW      = DATA_W,
  parameter int  AW      = ADDR_W,
  parameter bit  WRAP_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int PAD_W = DW - N_SRC;

  logic [N_SRC-1:0] stat, mask, clr_vec;
  logic             we_stat, we_mask, we_ctla, we_ctlb, we_wstat;
  logic             w_ena, w_gen, w_done, w_irq;
  logic             irq_q;
  logic [DW-1:0]    rdata_q, rd_mux;

  assign we_stat  = wr_en_i && (addr_i == A_STAT);
  assign we_mask  = wr_en_i && (addr_i == A_MASK);
  assign we_ctla  = wr_en_i && (addr_i == A_WCTLA);
  assign we_ctlb  = wr_en_i && (addr_i == A_WCTLB);
  assign we_wstat = wr_en_i && (addr_i == A_WSTAT);
  assign clr_vec  = we_stat ? wdata_i[N_SRC-1:0] : '0;

  irq_sticky_bank #(.W(N_SRC)) u_stat (
    .clk(clk), .rst(rst), .set_i(src_i), .clr_i(clr_vec), .stat_o(stat)
  );

  irq_mask_reg #(.W(N_SRC)) u_mask (
    .clk(clk), .rst(rst), .we_i(we_mask), .d_i(wdata_i[N_SRC-1:0]), .mask_o(mask)
  );

  if (WRAP_EN) begin : g_wrap
    irq_done_wrap u_wrap (
      .clk(clk), .rst(rst),
      .we_ena_i(we_ctla), .we_gen_i(we_ctlb), .we_clr_i(we_wstat),
      .ena_d_i(wdata_i[WDONE_BIT]), .gen_d_i(wdata_i[GEN_BIT]),
      .clr_d_i(wdata_i[WDONE_BIT]), .pkt_evt_i(src_i[PKT_DONE_BIT]),
      .ena_o(w_ena), .gen_o(w_gen), .done_o(w_done), .irq_o(w_irq)
    );
  end else begin : g_nowrap
    assign w_ena  = 1'b0;
    assign w_gen  = 1'b0;
    assign w_done = 1'b0;
    assign w_irq  = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_STAT:  rd_mux = {{PAD_W{1'b0}}, stat};
      A_MASK:  rd_mux = {{PAD_W{1'b0}}, mask};
      A_WCTLA: rd_mux[WDONE_BIT] = w_ena;
      A_WCTLB: rd_mux[GEN_BIT]   = w_gen;
      A_WSTAT: rd_mux[WDONE_BIT] = w_done;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rd_mux;
      irq_q <= (|(stat & mask)) | w_irq;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (|(stat & mask)) |=> irq_o);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!(|(stat & mask)) && !w_irq) |=> !irq_o);

  assert_done_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (w_done && !w_gen && !(|(stat & mask))) |=> !irq_o);
endmodule

// File: tb/irq_stat_unit_tb_top.sv
`timescale 1ns/1ps
module irq_stat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  src;
  logic        we, re;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  irq_stat_unit dut_i (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(we), .rd_en_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {src, mask, clear, expected status, expected irq}
  localparam logic [39:0] VEC [6] = '{
    {8'h80, 8'h80, 8'h00, 8'h80, 8'h01},
    {8'h0C, 8'h80, 8'h00, 8'h0C, 8'h00},
    {8'h24, 8'h04, 8'h04, 8'h20, 8'h00},
    {8'hFF, 8'h01, 8'hF0, 8'h0F, 8'h01},
    {8'h10, 8'h00, 8'h00, 8'h10, 8'h00},
    {8'h42, 8'h40, 8'h02, 8'h40, 8'h01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] s);
    @(negedge clk); src = s;
    @(negedge clk); src = 8'h00;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; src = '0; we = 0; re = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd0, d); chk("R1 status", d, 32'd0);
    rd(3'd1, d); chk("R1 mask", d, 32'd0);
    rd(3'd4, d); chk("R1 done flag", d, 32'd0);

    // R2 R3 R7 table walk
    for (int k = 0; k < 6; k++) begin
      wr(3'd0, 32'hFF);
      wr(3'd1, {24'd0, VEC[k][31:24]});
      pulse(VEC[k][39:32]);
      wr(3'd0, {24'd0, VEC[k][23:16]});
      @(negedge clk);
      chk("R7 irq vector", {31'd0, irq}, {31'd0, VEC[k][0]});
      rd(3'd0, d); chk("R2/R3 status vector", d, {24'd0, VEC[k][15:8]});
    end

    // R6 mask readback
    wr(3'd1, 32'hFFFF_FFA5);
    rd(3'd1, d); chk("R6 mask readback", d, 32'h0000_00A5);

    // R3 all clear
    pulse(8'hFF);
    wr(3'd0, 32'hFF);
    rd(3'd0, d); chk("R3 clear all", d, 32'd0);
    @(negedge clk);
    chk("R7 irq low after clear", {31'd0, irq}, 32'd0);

    // R4 event wins over clear in the same cycle
    @(negedge clk); src = 8'h08; we = 1'b1; addr = 3'd0; wdata = 32'h08;
    @(negedge clk); src = 8'h00; we = 1'b0;
    rd(3'd0, d); chk("R4 event wins", d, 32'h08);
    wr(3'd0, 32'hFF);

    // R5 level request held high
    @(negedge clk); src = 8'h01;
    wr(3'd0, 32'h01);
    wr(3'd0, 32'h01);
    rd(3'd0, d); chk("R5 level holds", d, 32'h01);
    @(negedge clk); src = 8'h00;
    wr(3'd0, 32'h01);
    rd(3'd0, d); chk("R5 clear after level drop", d, 32'd0);

    // R8 unmapped address and latency
    rd(3'd6, d); chk("R8 unmapped reads zero", d, 32'd0);
    chk("R8 rdata held", rdata, 32'd0);

    // R9 done flag needs enable
    wr(3'd1, 32'h00);
    pulse(8'h80);
    rd(3'd4, d); chk("R9 no set when disabled", d, 32'd0);
    wr(3'd2, 32'h4000_0000);
    rd(3'd2, d); chk("R8 ctl A readback", d, 32'h4000_0000);
    pulse(8'h80);
    rd(3'd4, d); chk("R9 done set", d, 32'h4000_0000);
    // R10 gated by global enable
    @(negedge clk);
    chk("R10 irq low without global enable", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h0000_0400);
    rd(3'd3, d); chk("R8 ctl B readback", d, 32'h0000_0400);
    chk("R10 irq with global enable", {31'd0, irq}, 32'd1);
    // R9 event wins over done clear
    @(negedge clk); src = 8'h80; we = 1'b1; addr = 3'd4; wdata = 32'h4000_0000;
    @(negedge clk); src = 8'h00; we = 1'b0;
    rd(3'd4, d); chk("R9 event wins done clear", d, 32'h4000_0000);
    wr(3'd4, 32'h4000_0000);
    rd(3'd4, d); chk("R9 done cleared", d, 32'd0);
    @(negedge clk);
    chk("R10 irq low after done clear", {31'd0, irq}, 32'd0);

    // R1 reset again
    pulse(8'hFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(3'd0, d); chk("R1 status after reset", d, 32'd0);
    rd(3'd2, d); chk("R1 ctl A after reset", d, 32'd0);

    finish_run();
  end
endmodule